// File: doc/BRIEF.md
# Device-Side Command Mailbox Register Block

This block is the device end of a host-to-device command mailbox. A host reaches it over a simple word-addressed register port. The port has read and write strobes, byte enables and a read result that arrives one cycle later. Through this port the host can:

- read a capability word giving the payload area size;
- write a command opcode and a payload length;
- fill a payload RAM;
- ring a doorbell.

The block then hands the command to a small internal executor and waits for it to answer. When the executor answers, the block posts the return code and the output length and clears the doorbell.

The host and the device take turns owning the doorbell. The host owns it while it reads as zero. The device owns it from the ring until it clears it. While the device owns it, host writes to the command fields and the payload are dropped. Once the device clears the doorbell, nothing on the device side changes until the next ring.

Readiness and timeout:

- A ready flag rises a fixed number of cycles after reset, and rings made before that are ignored.
- If the executor stays silent for a parameterised number of cycles, the block ends the command itself with a timeout code.

Word addresses: 0 capability, 1 control, 2 opcode, 3 length, 4 status, 5 device status. Any word address with its top bit set selects payload word `addr[PAY_EXP-3:0]`. Reads of unmapped words return zero.

Top module: `mbox_dev`

## Requirements
- R1: The capability word (address 0) reads the payload-size exponent PAY_EXP in bits [4:0]; the payload area is 2**PAY_EXP bytes, with PAY_EXP allowed from 8 to 20.
- R2: A read strobe returns the addressed word on reg_rdata one cycle later. Writes to the opcode, length and payload words update only the bytes whose reg_be bit is set (bit i covers data bits 8i+7..8i).
- R3: Control bit 0 (address 1) is the doorbell. It reads 0 after reset. A host write with reg_be[0]=1 and data bit 0 = 1, made while the doorbell is clear and the mailbox is ready, sets it and submits the opcode (address 2, bits [15:0]) and length (address 3, bits [20:0]).
- R4: While the doorbell is set, host writes cannot clear it; only the device clears it, on completion or timeout.
- R5: While the doorbell is set, host writes to the opcode, length and payload words are dropped, and reads still return their stored contents.
- R6: Device-status bit 4 (address 5) is the ready flag. It reads 0 until READY_DLY cycles after reset release and 1 from then on. A doorbell write made while it is 0 is ignored.
- R7: On completion the status word (address 4, bits [15:0]) takes the executor's return code, with 0 meaning success and any other value an error. The length word takes the executor's output length. Both change in the cycle the doorbell clears.
- R8: An output length larger than 2**PAY_EXP bytes is posted as exactly 2**PAY_EXP.
- R9: If the executor has not answered after TMO_CYCLES cycles of doorbell-set time, the doorbell clears and the status takes TMO_RC (default 16'h00FE) with length 0.
- R10: After the doorbell clears, the status, opcode, length and payload keep their values until the host changes them or rings again.
- R11: The executor answers after EXEC_LAT cycles as follows. Opcode 16'h0001 returns code 0 with output length equal to the input length. 16'h0002 returns code 16'h0005 with length 0. 16'h0003 returns code 0 with length 21'h1FFFFF. 16'h00FF never answers. Any other opcode returns code 16'h0002 with length 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | PAY_EXP-1 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables for writes |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |

## Verification
Several rules are checked by properties on every cycle:

- the opcode register never moves during a cycle that follows a set doorbell;
- the doorbell falls only on an executor answer or a timeout;
- a ring happens only while ready;
- the status changes only when the doorbell falls;
- a timeout posts its fixed code;
- a posted length never exceeds the payload size.

Other behaviour only the bench's scenarios can show: the byte-enable merges, the executor's per-opcode answers, the clamp value, the early-ring rejection, and the length of the timeout window measured at the register port.

// File: rtl/mbox_pkg.sv
// Shared constants for the command mailbox: register word indices,
// executor opcodes and return codes, and a byte-enable merge helper.
package mbox_pkg;
    localparam logic [2:0] RW_CAP    = 3'd0;
    localparam logic [2:0] RW_CTRL   = 3'd1;
    localparam logic [2:0] RW_OPC    = 3'd2;
    localparam logic [2:0] RW_LEN    = 3'd3;
    localparam logic [2:0] RW_STAT   = 3'd4;
    localparam logic [2:0] RW_DEVST  = 3'd5;

    localparam logic [15:0] OPC_ECHO = 16'h0001;
    localparam logic [15:0] OPC_FAIL = 16'h0002;
    localparam logic [15:0] OPC_BIG  = 16'h0003;
    localparam logic [15:0] OPC_HANG = 16'h00FF;

    localparam logic [15:0] RC_OK     = 16'h0000;
    localparam logic [15:0] RC_UNSUPP = 16'h0002;
    localparam logic [15:0] RC_FAIL   = 16'h0005;

    localparam int LEN_W = 21;

    // Merge new bytes into an old word under byte enables.
    function automatic logic [31:0] be_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
        logic [31:0] res;
        for (int i = 0; i < 4; i++)
            res[8*i +: 8] = be[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
        return res;
    endfunction
endpackage

// File: rtl/mbox_ready_timer.sv
// Raises the mailbox-ready flag DLY cycles after reset release and holds it.
// Assumes DLY >= 1.
module mbox_ready_timer #(
    parameter int DLY = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready_o
);
    localparam int CW = $clog2(DLY + 1);
    logic [CW-1:0] cnt;

    // Count up after reset until the delay has elapsed, then latch ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            ready_o <= 1'b0;
        end else if (!ready_o) begin
            cnt     <= cnt + 1'b1;
            ready_o <= (cnt == CW'(DLY - 1));
        end
    end
endmodule

// File: rtl/mbox_payload_ram.sv
// Payload store with byte-enable writes and an asynchronous read port.
// Assumes the caller gates the write enable while the doorbell is set.
module mbox_payload_ram #(
    parameter int WORDS = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [3:0]    be,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    import mbox_pkg::*;
    logic [31:0] mem [WORDS];

    // Store enabled bytes of the addressed word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= be_merge(mem[waddr], wdata, be);
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mbox_exec.sv
// Toy command executor behind the mailbox. It starts when req rises,
// answers once after LAT cycles and drops the command if req falls.
// Assumes opcode and in_len are stable while req is high.
module mbox_exec #(
    parameter int LAT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req,
    input  logic [15:0]                opcode,
    input  logic [mbox_pkg::LEN_W-1:0] in_len,
    output logic                       done,
    output logic [15:0]                rc,
    output logic [mbox_pkg::LEN_W-1:0] out_len
);
    import mbox_pkg::*;
    localparam int CW = $clog2(LAT + 1);
    typedef enum logic [1:0] {EX_IDLE, EX_RUN, EX_HOLD} ex_st_t;
    ex_st_t        st;
    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == CW'(LAT - 1));
    assign done   = (st == EX_RUN) && req && at_end && (opcode != OPC_HANG);

    // Per-opcode answer.
    always_comb begin
        case (opcode)
            OPC_ECHO: begin rc = RC_OK;     out_len = in_len;        end
            OPC_FAIL: begin rc = RC_FAIL;   out_len = '0;            end
            OPC_BIG:  begin rc = RC_OK;     out_len = {LEN_W{1'b1}}; end
            default:  begin rc = RC_UNSUPP; out_len = '0;            end
        endcase
    end

    // Sequence idle -> run -> hold, returning to idle when req drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= EX_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                EX_IDLE: if (req) begin st <= EX_RUN; cnt <= '0; end
                EX_RUN: begin
                    if (!req)        st  <= EX_IDLE;
                    else if (done)   st  <= EX_HOLD;
                    else if (!at_end) cnt <= cnt + 1'b1;
                end
                default: if (!req) st <= EX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mbox_dev.sv
// Device-side mailbox register block. It decodes host register accesses,
// owns the doorbell handshake, runs the executor and the timeout counter,
// and posts the return code and output length. Read data is registered,
// so it is valid one cycle after reg_rd.
module mbox_dev #(
    parameter int          PAY_EXP    = 8,
    parameter int          READY_DLY  = 16,
    parameter int          TMO_CYCLES = 500_000_000,
    parameter int          EXEC_LAT   = 4,
    parameter logic [15:0] TMO_RC     = 16'h00FE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PAY_EXP-2:0] reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic [3:0]         reg_be,
    input  logic               reg_wr,
    input  logic               reg_rd,
    output logic [31:0]        reg_rdata
);
    import mbox_pkg::*;
    localparam int AW        = PAY_EXP - 1;
    localparam int PAW       = PAY_EXP - 2;
    localparam int PAY_BYTES = 1 << PAY_EXP;
    localparam int PAY_WORDS = PAY_BYTES / 4;
    localparam int TW        = $clog2(TMO_CYCLES + 1);

    logic              ready, db_q, host_ok, ring, tmo_hit, is_pay;
    logic [15:0]       op_q, rc_q, ex_rc;
    logic [LEN_W-1:0]  len_q, ex_len, len_clamped;
    logic [TW-1:0]     tmo_cnt;
    logic              ex_done;
    logic [31:0]       pay_rd, rd_mux;

    assign is_pay  = reg_addr[AW-1];
    assign host_ok = reg_wr && !db_q;
    assign ring    = reg_wr && (reg_addr == AW'(RW_CTRL)) && reg_be[0]
                     && reg_wdata[0] && !db_q && ready;
    assign tmo_hit = db_q && !ex_done && (tmo_cnt == TW'(TMO_CYCLES - 1));
    assign len_clamped = (ex_len > LEN_W'(PAY_BYTES)) ? LEN_W'(PAY_BYTES) : ex_len;

    mbox_ready_timer #(.DLY(READY_DLY)) u_ready (
        .clk(clk), .rst_n(rst_n), .ready_o(ready));

    mbox_payload_ram #(.WORDS(PAY_WORDS), .AW(PAW)) u_ram (
        .clk(clk), .we(host_ok && is_pay), .waddr(reg_addr[PAW-1:0]),
        .wdata(reg_wdata), .be(reg_be), .raddr(reg_addr[PAW-1:0]),
        .rdata(pay_rd));

    mbox_exec #(.LAT(EXEC_LAT)) u_exec (
        .clk(clk), .rst_n(rst_n), .req(db_q), .opcode(op_q), .in_len(len_q),
        .done(ex_done), .rc(ex_rc), .out_len(ex_len));

    // Command fields, doorbell and completion posting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_q  <= 1'b0;
            op_q  <= '0;
            len_q <= '0;
            rc_q  <= '0;
        end else begin
            if (host_ok && reg_addr == AW'(RW_OPC)) begin
                if (reg_be[0]) op_q[7:0]  <= reg_wdata[7:0];
                if (reg_be[1]) op_q[15:8] <= reg_wdata[15:8];
            end
            if (host_ok && reg_addr == AW'(RW_LEN)) begin
                if (reg_be[0]) len_q[7:0]   <= reg_wdata[7:0];
                if (reg_be[1]) len_q[15:8]  <= reg_wdata[15:8];
                if (reg_be[2]) len_q[20:16] <= reg_wdata[20:16];
            end
            if (ring) begin
                db_q <= 1'b1;
            end else if (db_q && ex_done) begin
                db_q  <= 1'b0;
                rc_q  <= ex_rc;
                len_q <= len_clamped;
            end else if (tmo_hit) begin
                db_q  <= 1'b0;
                rc_q  <= TMO_RC;
                len_q <= '0;
            end
        end
    end

    // Busy-time counter for the execution budget.
    always_ff @(posedge clk) begin
        if (!rst_n) tmo_cnt <= '0;
        else        tmo_cnt <= db_q ? tmo_cnt + 1'b1 : '0;
    end

    // Read-side decode.
    always_comb begin
        rd_mux = '0;
        if (is_pay) rd_mux = pay_rd;
        else case (reg_addr)
            AW'(RW_CAP):   rd_mux = 32'(PAY_EXP);
            AW'(RW_CTRL):  rd_mux = {31'd0, db_q};
            AW'(RW_OPC):   rd_mux = {16'd0, op_q};
            AW'(RW_LEN):   rd_mux = {11'd0, len_q};
            AW'(RW_STAT):  rd_mux = {16'd0, rc_q};
            AW'(RW_DEVST): rd_mux = {27'd0, ready, 4'd0};
            default:       rd_mux = '0;
        endcase
    end

    // Register the read result.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // R5
    op_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(db_q) |-> $stable(op_q));
    // R4
    db_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(db_q) |-> $past(ex_done || tmo_hit));
    // R6
    ring_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(db_q) |-> ready);
    // R10
    stat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rc_q) |-> $fell(db_q));
    // R9
    tmo_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |=> (!db_q && rc_q == TMO_RC && len_q == '0));
    // R8
    len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(db_q) |-> (len_q <= LEN_W'(PAY_BYTES)));
endmodule

// File: tb/mbox_dev_bench.sv
`timescale 1ns/1ps
module mbox_dev_bench;
    localparam int PAY_EXP = 8;
    localparam int TMO     = 64;
    localparam int AW      = PAY_EXP - 1;
    localparam logic [AW-1:0] A_CAP = 0, A_CTRL = 1, A_OPC = 2, A_LEN = 3,
                              A_STAT = 4, A_DEV = 5;
    localparam logic [AW-1:0] A_PAY = 7'h40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_be = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_rdata;

    always #2 clk = ~clk;

    mbox_dev #(.PAY_EXP(PAY_EXP), .READY_DLY(12), .TMO_CYCLES(TMO),
               .EXEC_LAT(4), .TMO_RC(16'h00FE)) u_mbox_dev (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_be(reg_be), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata));

    typedef struct { logic [31:0] exp; string tag; } sb_item_t;
    sb_item_t sbq[$];
    int n_vec = 0, n_err = 0;
    int unsigned cyc = 0;
    logic sb_arm = 1'b0, mon_take = 1'b0;
    bit finished = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mon_take <= reg_rd && sb_arm;
    end

    // Monitor: pop and compare each scoreboarded read result.
    always @(negedge clk) begin
        if (mon_take && sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            n_vec++;
            if (reg_rdata !== it.exp) begin
                n_err++;
                $display("FAIL %s: got %h expected %h", it.tag, reg_rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic rd_raw(input logic [AW-1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        #1 v = reg_rdata;
    endtask

    // Driver: push the expected word, then issue the read.
    task automatic expect_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        logic [31:0] v;
        sb_item_t it;
        it.exp = e; it.tag = tag;
        sbq.push_back(it);
        sb_arm = 1'b1;
        rd_raw(a, v);
        sb_arm = 1'b0;
    endtask

    task automatic wait_clear(output int unsigned at);
        logic [31:0] v;
        v = 32'd1;
        for (int i = 0; i < 500 && v[0]; i++) rd_raw(A_CTRL, v);
        at = cyc;
    endtask

    task automatic run_cmd(input logic [15:0] op, input logic [20:0] len);
        int unsigned t;
        wr(A_OPC, {16'd0, op}, 4'hF);
        wr(A_LEN, {11'd0, len}, 4'hF);
        wr(A_CTRL, 32'd1, 4'h1);
        wait_clear(t);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_err++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
        end
    end

    initial begin
        int unsigned t0, t1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R6 R3: reset state, not yet ready
        expect_rd(A_DEV, 32'h0, "R6 ready low after reset");
        expect_rd(A_CTRL, 32'h0, "R3 doorbell clear after reset");
        expect_rd(A_STAT, 32'h0, "R7 status zero after reset");
        // R6: early ring ignored
        wr(A_CTRL, 32'd1, 4'h1);
        expect_rd(A_CTRL, 32'h0, "R6 early ring ignored");
        repeat (20) @(negedge clk);
        expect_rd(A_DEV, 32'h10, "R6 ready high");
        expect_rd(A_CAP, 32'd8, "R1 payload exponent");
        // R2: payload byte enables
        wr(A_PAY, 32'hA5A5_1234, 4'hF);
        wr(A_PAY + 5, 32'hDEAD_BEEF, 4'hF);
        wr(A_PAY + 5, 32'h1122_3344, 4'b0101);
        expect_rd(A_PAY, 32'hA5A5_1234, "R2 full word");
        expect_rd(A_PAY + 5, 32'hDE22_BE44, "R2 byte merge");
        wr(A_OPC, 32'hFFFF_0001, 4'b0001);
        expect_rd(A_OPC, 32'h0000_0001, "R2 opcode byte write");
        // R3 R7 R11: echo command
        wr(A_LEN, 32'd12, 4'hF);
        wr(A_CTRL, 32'd1, 4'h1);
        expect_rd(A_CTRL, 32'h1, "R3 doorbell set after ring");
        wait_clear(t0);
        expect_rd(A_STAT, 32'h0, "R7 echo success code");
        expect_rd(A_LEN, 32'd12, "R11 echo length");
        expect_rd(A_PAY, 32'hA5A5_1234, "R10 payload kept");
        // R11: error and unsupported codes
        run_cmd(16'h0002, 21'd4);
        expect_rd(A_STAT, 32'h5, "R11 failing opcode code");
        expect_rd(A_LEN, 32'h0, "R11 failing opcode length");
        run_cmd(16'h0042, 21'd4);
        expect_rd(A_STAT, 32'h2, "R11 unsupported opcode");
        // R8: clamp
        run_cmd(16'h0003, 21'd8);
        expect_rd(A_LEN, 32'd256, "R8 length clamped");
        expect_rd(A_STAT, 32'h0, "R8 clamp success code");
        // R4 R5 R9: hung command
        wr(A_OPC, 32'h00FF, 4'hF);
        wr(A_LEN, 32'd4, 4'hF);
        wr(A_CTRL, 32'd1, 4'h1);
        t0 = cyc;
        wr(A_CTRL, 32'd0, 4'hF);
        expect_rd(A_CTRL, 32'h1, "R4 host cannot clear doorbell");
        wr(A_OPC, 32'h1234, 4'hF);
        expect_rd(A_OPC, 32'h00FF, "R5 opcode write dropped");
        wr(A_PAY, 32'h0, 4'hF);
        expect_rd(A_PAY, 32'hA5A5_1234, "R5 payload write dropped");
        wait_clear(t1);
        n_vec++;
        if (t1 - t0 < TMO - 4 || t1 - t0 > TMO + 8) begin
            n_err++;
            $display("FAIL R9 timeout window: got %0d expected %0d", t1 - t0, TMO);
        end
        expect_rd(A_STAT, 32'h00FE, "R9 timeout code");
        expect_rd(A_LEN, 32'h0, "R9 timeout length");
        // R10: frozen after clear
        repeat (20) @(negedge clk);
        expect_rd(A_STAT, 32'h00FE, "R10 status frozen");
        expect_rd(A_OPC, 32'h00FF, "R10 opcode frozen");
        // R3: mailbox usable again
        run_cmd(16'h0001, 21'd20);
        expect_rd(A_STAT, 32'h0, "R3 command after timeout");
        expect_rd(A_LEN, 32'd20, "R7 length after timeout");
        repeat (3) @(negedge clk);
        finished = 1;
        summary();
    end
endmodule